// File: doc/BRIEF.md
# Integer Datapath Unit with Condition Flags

This block is the 32-bit integer execution stage of a small processor core. It combines an adder/subtractor, a bitwise unit and a saturating clamp with a registered set of five condition flags: negative, zero, carry, overflow and a sticky saturation flag. The second operand reaches the block after the operand shifter has already processed it, and that shifter's carry-out arrives with it. The result is combinational and valid in the same cycle. Flag changes are registered and become visible after the next rising clock edge.

The caller picks an opcode, supplies both operands, and raises `set_flags` when the flags should follow the operation. Compare and test opcodes always update flags and never request a result write. Saturation opcodes clamp the first operand to a signed or unsigned range of `sat_n` bits, and they raise the sticky flag whenever they clamp. A separate write port loads all five flags at once. This port is the only way to clear the sticky flag.

Top module: `alu_flags_unit`

## Requirements
- R1: While reset is low, all flags read 0. `flags_o` is ordered [4] negative, [3] zero, [2] carry, [1] overflow, [0] saturation.
- R2: Outside a compare/test or saturation opcode, with `set_flags` low and no flag write, every flag holds its previous value. The result is still produced and `result_we` is 1.
- R3: When an arithmetic, logical, compare or test opcode updates flags, negative becomes bit 31 of its value and zero becomes 1 exactly when that 32-bit value is 0.
- R4: Opcode 0 (add) gives a+b and opcode 1 (add with carry) gives a+b+C. Carry becomes the unsigned carry out of bit 31 and overflow becomes the signed two's-complement overflow.
- R5: Opcode 2 (subtract) gives a-b and opcode 3 (subtract with carry) gives a-b+C-1. Carry becomes 1 when no borrow occurred and 0 otherwise. Overflow is the signed overflow.
- R6: Opcode 4 (reverse subtract) gives b-a, with carry and overflow taken in that operand order.
- R7: The logical opcodes give these results: 5 a&b, 6 a|b, 7 a^b, 8 a|~b, 9 a&~b, 10 b, 11 ~b. When flags update, carry is taken from `shift_carry` and overflow is left unchanged.
- R8: Opcodes 12 (a-b), 13 (a+b), 14 (a&b) and 15 (a^b) update flags even when `set_flags` is low, and they drive `result_we` to 0. Opcodes 12 and 13 set all four of N, Z, C and V. Opcodes 14 and 15 set N and Z, take carry from `shift_carry`, and keep overflow.
- R9: Arithmetic opcodes take carry from the adder and ignore `shift_carry`.
- R10: Opcode 16 clamps signed a to the range -2^(n-1) .. 2^(n-1)-1, for n = `sat_n` from 1 to 32.
- R11: Opcode 17 clamps signed a to the range 0 .. 2^n-1, for n = `sat_n` from 0 to 31.
- R12: A saturation opcode that clamps sets the saturation flag. No operation ever clears that flag, and saturation opcodes never change N, Z, C or V, even when `set_flags` is high.
- R13: When `flag_wr_en` is high, the flags load `flag_wr_val` (bit 4 negative through bit 0 saturation) at the next edge. In that same cycle this load overrides any update from the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Opcode |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, already shifted |
| shift_carry | input | 1 | Carry-out of the operand shifter |
| set_flags | input | 1 | Request flag update |
| sat_n | input | 6 | Saturation bit count |
| flag_wr_en | input | 1 | Direct flag load enable |
| flag_wr_val | input | 5 | Flag values to load |
| result_o | output | 32 | Operation value |
| result_we | output | 1 | Result should be written |
| flags_o | output | 5 | Current flags N,Z,C,V,Q |

## Verification
A direct flag load can arrive in the same cycle as an operation that would also change the flags. Two such operations are an add issued with `set_flags` high and a signed saturation that clamps and so would raise the sticky flag. The bench provokes both collisions by raising `flag_wr_en` alongside each operation. After the edge it requires the flags to equal the loaded value exactly, with nothing from the operation in them. The bench also checks that the sticky flag survives later operations that do not clamp.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,
      OP_ADC  = 5'd1,
      OP_SUB  = 5'd2,
      OP_SBC  = 5'd3,
      OP_RSB  = 5'd4,
      OP_AND  = 5'd5,
      OP_ORR  = 5'd6,
      OP_EOR  = 5'd7,
      OP_ORN  = 5'd8,
      OP_BIC  = 5'd9,
      OP_MOV  = 5'd10,
      OP_MVN  = 5'd11,
      OP_CMP  = 5'd12,
      OP_CMN  = 5'd13,
      OP_TST  = 5'd14,
      OP_TEQ  = 5'd15,
      OP_SSAT = 5'd16,
      OP_USAT = 5'd17
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
      logic q;
   } alu_flags_t;

   function automatic logic op_is_cmp(input logic [4:0] op);
      return op >= 5'd12 && op <= 5'd15;
   endfunction

   // adder-based opcodes, including the two compares
   function automatic logic op_is_arith(input logic [4:0] op);
      return op <= 5'd4 || op == 5'd12 || op == 5'd13;
   endfunction

   // bitwise opcodes, including the two tests
   function automatic logic op_is_logic(input logic [4:0] op);
      return (op >= 5'd5 && op <= 5'd11) || op == 5'd14 || op == 5'd15;
   endfunction

   function automatic logic op_is_sat(input logic [4:0] op);
      return op == 5'd16 || op == 5'd17;
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
   import alu_flags_pkg::*;
#(
   parameter int W = 32
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic           c_flag,
   output logic [W-1:0]   sum,
   output logic           cout,
   output logic           ovf
);
   logic [W-1:0] x, y;
   logic         cin;

   // subtraction is x + ~y + 1; borrow-chaining replaces the 1 by C
   always_comb begin
      x   = a;
      y   = b;
      cin = 1'b0;
      unique case (op)
         OP_ADC:         cin = c_flag;
         OP_SUB, OP_CMP: begin y = ~b; cin = 1'b1; end
         OP_SBC:         begin y = ~b; cin = c_flag; end
         OP_RSB:         begin x = b; y = ~a; cin = 1'b1; end
         default:        ;
      endcase
   end

   always_comb begin
      {cout, sum} = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
      ovf = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
   end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
   import alu_flags_pkg::*;
#(
   parameter int W = 32
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   y
);
   always_comb begin
      unique case (op)
         OP_AND, OP_TST: y = a & b;
         OP_ORR:         y = a | b;
         OP_EOR, OP_TEQ: y = a ^ b;
         OP_ORN:         y = a | ~b;
         OP_BIC:         y = a & ~b;
         OP_MVN:         y = ~b;
         default:        y = b;
      endcase
   end
endmodule

// File: rtl/alu_saturate.sv
module alu_saturate #(
   parameter int W  = 32,
   parameter int NB = $clog2(W) + 1
) (
   input  logic [W-1:0]   a,
   input  logic [NB-1:0]  n,
   input  logic           signed_mode,
   output logic [W-1:0]   y,
   output logic           clamped
);
   localparam logic [W:0] ONE = {{W{1'b0}}, 1'b1};

   logic signed [W:0] x, hi, lo;
   logic [NB-1:0]     ns, nu;

   // keep bit counts inside the legal range of each mode
   always_comb begin
      ns = n;
      if (n == '0) ns = NB'(1);
      if (n > NB'(W)) ns = NB'(W);
      nu = n;
      if (n > NB'(W - 1)) nu = NB'(W - 1);
   end

   always_comb begin
      x = $signed({a[W-1], a});
      if (signed_mode) begin
         hi = $signed((ONE << (ns - NB'(1))) - ONE);
         lo = -$signed(ONE << (ns - NB'(1)));
      end else begin
         hi = $signed((ONE << nu) - ONE);
         lo = '0;
      end
      if (x > hi) begin
         y = hi[W-1:0];
         clamped = 1'b1;
      end else if (x < lo) begin
         y = lo[W-1:0];
         clamped = 1'b1;
      end else begin
         y = a;
         clamped = 1'b0;
      end
   end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import alu_flags_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  alu_flags_t  wr_val,
   input  logic        upd_nzc,
   input  logic        upd_v,
   input  logic        set_q,
   input  logic        n_in,
   input  logic        z_in,
   input  logic        c_in,
   input  logic        v_in,
   output alu_flags_t  flags
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else if (wr_en) begin
         flags <= wr_val;
      end else begin
         if (upd_nzc) begin
            flags.n <= n_in;
            flags.z <= z_in;
            flags.c <= c_in;
         end
         if (upd_v) flags.v <= v_in;
         if (set_q) flags.q <= 1'b1;
      end
   end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
   import alu_flags_pkg::*;
#(
   parameter int W      = 32,
   parameter bit SAT_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [4:0]           op_i,
   input  logic [W-1:0]         opnd_a,
   input  logic [W-1:0]         opnd_b,
   input  logic                 shift_carry,
   input  logic                 set_flags,
   input  logic [$clog2(W):0]   sat_n,
   input  logic                 flag_wr_en,
   input  logic [4:0]           flag_wr_val,
   output logic [W-1:0]         result_o,
   output logic                 result_we,
   output logic [4:0]           flags_o
);
   localparam int NB = $clog2(W) + 1;

   if (W < 8) begin : g_bad_width
      $error("alu_flags_unit: W must be at least 8");
   end

   alu_op_e      op;
   alu_flags_t   cur;
   logic [W-1:0] sum, bits, sat_y;
   logic         cout, ovf, clamped;
   logic         is_cmp, is_arith, is_logic, is_sat, upd;
   logic         c_sel;

   assign op       = alu_op_e'(op_i);
   assign is_cmp   = op_is_cmp(op_i);
   assign is_arith = op_is_arith(op_i);
   assign is_logic = op_is_logic(op_i);
   assign is_sat   = op_is_sat(op_i);
   assign upd      = set_flags | is_cmp;

   alu_addsub #(.W(W)) u_add (
      .op(op), .a(opnd_a), .b(opnd_b), .c_flag(cur.c),
      .sum(sum), .cout(cout), .ovf(ovf)
   );

   alu_bitwise #(.W(W)) u_bit (
      .op(op), .a(opnd_a), .b(opnd_b), .y(bits)
   );

   if (SAT_EN) begin : g_sat
      alu_saturate #(.W(W), .NB(NB)) u_sat (
         .a(opnd_a), .n(sat_n), .signed_mode(op == OP_SSAT),
         .y(sat_y), .clamped(clamped)
      );
   end else begin : g_nosat
      logic unused_n;
      assign unused_n = ^sat_n;
      assign sat_y    = opnd_a;
      assign clamped  = 1'b0;
   end

   always_comb begin
      if (is_arith)      result_o = sum;
      else if (is_sat)   result_o = sat_y;
      else               result_o = bits;
   end

   assign result_we = ~is_cmp;
   assign c_sel     = is_arith ? cout : shift_carry;

   alu_flag_reg u_flags (
      .clk(clk), .rst_n(rst_n),
      .wr_en(flag_wr_en), .wr_val(alu_flags_t'(flag_wr_val)),
      .upd_nzc(upd & (is_arith | is_logic)),
      .upd_v(upd & is_arith),
      .set_q(is_sat & clamped),
      .n_in(result_o[W-1]), .z_in(result_o == '0),
      .c_in(c_sel), .v_in(ovf),
      .flags(cur)
   );

   assign flags_o = cur;

endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk
   import alu_flags_pkg::*;
#(
   parameter int W = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [4:0]           op_i,
   input logic                 shift_carry,
   input logic                 set_flags,
   input logic                 flag_wr_en,
   input logic [4:0]           flag_wr_val,
   input logic [W-1:0]         result_o,
   input logic                 result_we,
   input logic [4:0]           flags_o
);
   logic cmp_op, ar_op, lg_op, st_op;
   assign cmp_op = op_is_cmp(op_i);
   assign ar_op  = op_is_arith(op_i);
   assign lg_op  = op_is_logic(op_i);
   assign st_op  = op_is_sat(op_i);

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_wr_en && !set_flags && !cmp_op && !st_op) |=> $stable(flags_o));

   p_nz_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_wr_en && (set_flags || cmp_op) && (ar_op || lg_op)) |=>
         (flags_o[4] == $past(result_o[W-1]) && flags_o[3] == ($past(result_o) == '0)));

   p_logic_cv_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_wr_en && (set_flags || cmp_op) && lg_op) |=>
         (flags_o[2] == $past(shift_carry) && flags_o[1] == $past(flags_o[1])));

   p_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_op |-> !result_we);

   p_q_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_wr_en && flags_o[0]) |=> flags_o[0]);

   p_sat_keeps_nzcv_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_wr_en && st_op) |=> (flags_o[4:1] == $past(flags_o[4:1])));

   p_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
      flag_wr_en |=> (flags_o == $past(flag_wr_val)));

endmodule

bind alu_flags_unit alu_flags_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_i(op_i), .shift_carry(shift_carry),
   .set_flags(set_flags), .flag_wr_en(flag_wr_en), .flag_wr_val(flag_wr_val),
   .result_o(result_o), .result_we(result_we), .flags_o(flags_o)
);

// File: tb/sim_alu_flags_unit.sv
module sim_alu_flags_unit;
   import alu_flags_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  op_i = 5'd10;
   logic [31:0] opnd_a = '0, opnd_b = '0;
   logic        shift_carry = 1'b0, set_flags = 1'b0;
   logic [5:0]  sat_n = 6'd8;
   logic        flag_wr_en = 1'b0;
   logic [4:0]  flag_wr_val = '0;
   logic [31:0] result_o;
   logic        result_we;
   logic [4:0]  flags_o;

   int n_chk = 0, n_err = 0;
   logic [31:0] r_res;
   logic        r_we;
   logic [4:0]  r_flg;

   always #2 clk = ~clk;

   alu_flags_unit u0 (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .shift_carry(shift_carry), .set_flags(set_flags), .sat_n(sat_n),
      .flag_wr_en(flag_wr_en), .flag_wr_val(flag_wr_val),
      .result_o(result_o), .result_we(result_we), .flags_o(flags_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one operation: result sampled mid-cycle, flags sampled after the edge
   task automatic run(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic sc, input logic sf, input logic [5:0] n,
                      input logic we, input logic [4:0] wv);
      @(negedge clk);
      op_i = op; opnd_a = a; opnd_b = b; shift_carry = sc; set_flags = sf;
      sat_n = n; flag_wr_en = we; flag_wr_val = wv;
      #1;
      r_res = result_o;
      r_we  = result_we;
      @(posedge clk);
      #1;
      op_i = OP_MOV; set_flags = 1'b0; flag_wr_en = 1'b0;
      r_flg = flags_o;
   endtask

   task automatic op2(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic sc, input logic sf);
      run(op, a, b, sc, sf, 6'd8, 1'b0, 5'd0);
   endtask

   task automatic load_flags(input logic [4:0] v);
      run(OP_MOV, 0, 0, 1'b0, 1'b0, 6'd8, 1'b1, v);
   endtask

   task automatic t_reset;
      chk("R1 reset flags", {27'd0, flags_o}, 32'd0);
   endtask

   task automatic t_add;
      op2(OP_ADD, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1);
      chk("R4 add wrap result", r_res, 32'd0);
      chk("R3 R4 add wrap flags", {27'd0, r_flg}, 32'b01100);
      op2(OP_ADD, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b1);
      chk("R4 add ovf result", r_res, 32'h8000_0000);
      chk("R3 R4 add ovf flags", {27'd0, r_flg}, 32'b10010);
      op2(OP_ADD, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1);
      chk("R4 add carry flags", {27'd0, r_flg}, 32'b10100);
      op2(OP_ADC, 32'd1, 32'd2, 1'b0, 1'b1);
      chk("R4 adc result", r_res, 32'd4);
      chk("R4 adc flags", {27'd0, r_flg}, 32'b00000);
   endtask

   task automatic t_sub;
      op2(OP_SUB, 32'd5, 32'd3, 1'b0, 1'b1);
      chk("R5 sub result", r_res, 32'd2);
      chk("R5 sub no borrow", {27'd0, r_flg}, 32'b00100);
      op2(OP_SUB, 32'd3, 32'd5, 1'b0, 1'b1);
      chk("R5 sub borrow result", r_res, 32'hFFFF_FFFE);
      chk("R5 sub borrow flags", {27'd0, r_flg}, 32'b10000);
      op2(OP_SUB, 32'h8000_0000, 32'd1, 1'b0, 1'b1);
      chk("R5 sub ovf flags", {27'd0, r_flg}, 32'b00110);
      op2(OP_SBC, 32'd10, 32'd3, 1'b0, 1'b1);
      chk("R5 sbc carry set", r_res, 32'd7);
      op2(OP_SUB, 32'd0, 32'd1, 1'b0, 1'b1);
      chk("R5 sub 0-1 flags", {27'd0, r_flg}, 32'b10000);
      op2(OP_SBC, 32'd10, 32'd3, 1'b0, 1'b1);
      chk("R5 sbc carry clear", r_res, 32'd6);
      chk("R5 sbc flags", {27'd0, r_flg}, 32'b00100);
   endtask

   task automatic t_rsb;
      op2(OP_RSB, 32'd3, 32'd10, 1'b0, 1'b1);
      chk("R6 rsb result", r_res, 32'd7);
      chk("R6 rsb flags", {27'd0, r_flg}, 32'b00100);
      op2(OP_RSB, 32'd10, 32'd3, 1'b0, 1'b1);
      chk("R6 rsb neg result", r_res, 32'hFFFF_FFF9);
      chk("R6 rsb neg flags", {27'd0, r_flg}, 32'b10000);
   endtask

   task automatic t_arith_sc;
      op2(OP_ADD, 32'd1, 32'd1, 1'b1, 1'b1);
      chk("R9 adder carry wins", {27'd0, r_flg}, 32'b00000);
   endtask

   task automatic t_hold;
      op2(OP_ADD, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0);
      chk("R2 result without update", r_res, 32'd0);
      chk("R2 write enable", {31'd0, r_we}, 32'd1);
      chk("R2 flags held add", {27'd0, r_flg}, 32'b00000);
      op2(OP_SUB, 32'd0, 32'd1, 1'b1, 1'b0);
      chk("R2 flags held sub", {27'd0, r_flg}, 32'b00000);
   endtask

   task automatic t_logic;
      logic [31:0] a = 32'hF0F0_1234, b = 32'h0FF0_00FF;
      load_flags(5'b00010);
      op2(OP_AND, a, b, 1'b1, 1'b1);
      chk("R7 and", r_res, 32'h00F0_0034);
      chk("R7 and flags", {27'd0, r_flg}, 32'b00110);
      op2(OP_ORR, a, b, 1'b0, 1'b1);
      chk("R7 orr", r_res, 32'hFFF0_12FF);
      chk("R7 orr flags", {27'd0, r_flg}, 32'b10010);
      op2(OP_EOR, a, b, 1'b1, 1'b1);
      chk("R7 eor", r_res, 32'hFF00_12CB);
      chk("R7 eor flags", {27'd0, r_flg}, 32'b10110);
      op2(OP_ORN, a, b, 1'b0, 1'b1);
      chk("R7 orn", r_res, 32'hF0FF_FF34);
      chk("R7 orn flags", {27'd0, r_flg}, 32'b10010);
      op2(OP_BIC, a, b, 1'b1, 1'b1);
      chk("R7 bic", r_res, 32'hF000_1200);
      chk("R7 bic flags", {27'd0, r_flg}, 32'b10110);
      op2(OP_MOV, a, b, 1'b0, 1'b1);
      chk("R7 mov", r_res, b);
      chk("R7 mov flags", {27'd0, r_flg}, 32'b00010);
      op2(OP_MVN, a, 32'hFFFF_FFFF, 1'b1, 1'b1);
      chk("R7 mvn", r_res, 32'd0);
      chk("R3 R7 mvn flags", {27'd0, r_flg}, 32'b01110);
   endtask

   task automatic t_compare;
      op2(OP_CMP, 32'd5, 32'd5, 1'b0, 1'b0);
      chk("R8 cmp no write", {31'd0, r_we}, 32'd0);
      chk("R8 cmp flags", {27'd0, r_flg}, 32'b01100);
      op2(OP_CMN, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0);
      chk("R8 cmn no write", {31'd0, r_we}, 32'd0);
      chk("R8 cmn flags", {27'd0, r_flg}, 32'b10010);
      op2(OP_TST, 32'hA, 32'h5, 1'b0, 1'b0);
      chk("R8 tst flags", {27'd0, r_flg}, 32'b01010);
      op2(OP_TEQ, 32'hA, 32'hA, 1'b1, 1'b0);
      chk("R8 teq equal flags", {27'd0, r_flg}, 32'b01110);
      op2(OP_TEQ, 32'hA, 32'h5, 1'b0, 1'b0);
      chk("R8 teq differ flags", {27'd0, r_flg}, 32'b00010);
      chk("R8 teq no write", {31'd0, r_we}, 32'd0);
   endtask

   task automatic t_ssat;
      run(OP_SSAT, 32'd200, 0, 1'b0, 1'b0, 6'd8, 1'b0, 5'd0);
      chk("R10 ssat high", r_res, 32'd127);
      chk("R12 ssat sets q", {27'd0, r_flg}, 32'b00011);
      run(OP_SSAT, -32'sd300, 0, 1'b0, 1'b0, 6'd8, 1'b0, 5'd0);
      chk("R10 ssat low", r_res, 32'hFFFF_FF80);
      run(OP_SSAT, 32'd50, 0, 1'b0, 1'b0, 6'd8, 1'b0, 5'd0);
      chk("R10 ssat inside", r_res, 32'd50);
      run(OP_SSAT, 32'h8000_0000, 0, 1'b0, 1'b0, 6'd32, 1'b0, 5'd0);
      chk("R10 ssat full width", r_res, 32'h8000_0000);
      run(OP_SSAT, 32'd1, 0, 1'b0, 1'b0, 6'd1, 1'b0, 5'd0);
      chk("R10 ssat one bit", r_res, 32'd0);
   endtask

   task automatic t_usat;
      load_flags(5'b00000);
      run(OP_USAT, 32'd100, 0, 1'b0, 1'b0, 6'd8, 1'b0, 5'd0);
      chk("R11 usat inside", r_res, 32'd100);
      chk("R11 usat no clamp no q", {27'd0, r_flg}, 32'b00000);
      run(OP_USAT, 32'd300, 0, 1'b0, 1'b0, 6'd8, 1'b0, 5'd0);
      chk("R11 usat high", r_res, 32'd255);
      chk("R11 usat q", {27'd0, r_flg}, 32'b00001);
      run(OP_USAT, 32'hFFFF_FFFB, 0, 1'b0, 1'b0, 6'd8, 1'b0, 5'd0);
      chk("R11 usat negative", r_res, 32'd0);
      run(OP_USAT, 32'd1, 0, 1'b0, 1'b0, 6'd0, 1'b0, 5'd0);
      chk("R11 usat zero bits", r_res, 32'd0);
   endtask

   task automatic t_q_sticky;
      op2(OP_ADD, 32'd1, 32'd1, 1'b0, 1'b1);
      chk("R12 q survives add", {27'd0, r_flg}, 32'b00001);
      run(OP_SSAT, 32'hFFFF_FFFF, 0, 1'b1, 1'b1, 6'd8, 1'b0, 5'd0);
      chk("R12 sat leaves nzcv", {27'd0, r_flg}, 32'b00001);
   endtask

   task automatic t_collision;
      run(OP_ADD, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1, 6'd8, 1'b1, 5'b10100);
      chk("R13 load beats add", {27'd0, r_flg}, 32'b10100);
      run(OP_SSAT, 32'd500, 0, 1'b0, 1'b0, 6'd8, 1'b1, 5'b00000);
      chk("R13 load beats q set", {27'd0, r_flg}, 32'b00000);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_add();
      t_sub();
      t_rsb();
      t_arith_sc();
      t_hold();
      t_logic();
      t_compare();
      t_ssat();
      t_usat();
      t_q_sticky();
      t_collision();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule